// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a two-wire management target that holds a six-entry register file of control and identification bytes. A host reaches it with indexed block transfers. A block write carries the target address with the write bit, a starting register index, a byte count and then that many data bytes. A block read sets the index the same way and then issues a repeated start with the read address. The target answers with the current contents of the count register, followed by that many data bytes taken from the index onward.

The bus lines are sampled by the fast system clock through a synchronizer. From the sampled lines the block finds start, repeated start and stop conditions and the clock edges. It only ever pulls the data line low; it never releases it high actively and never stretches the clock. Control register 0 sets the two PLL control outputs of the chip. When its select bit is set, the outputs follow the register bits. When the bit is clear, they follow two strap inputs.

No data crosses the block edge as a stream. The register contents leave only as plain control levels, so the block has no valid/ready handshake and applies no back-pressure. The bus pace is set entirely by the host clock.

Top module: `smb_regblk`

## Requirements
- R1: The 8-bit addresses 0xD4 (write) and 0xD5 (read) are acknowledged. Any other address byte gets a NACK, and the block then leaves SDA released for every later byte until the next start.
- R2: In a block write, the index byte, the count byte and each data byte are acknowledged. Data byte k (counting from 0) is stored at index N+k.
- R3: Data bytes that go beyond the written count get a NACK and are not stored.
- R4: A block read first returns the value of register 5 and then returns the registers from index N upward.
- R5: A read supplies exactly as many data bytes as register 5 holds. If the host acknowledges further bytes, it reads 0xFF because SDA stays released.
- R6: A host NACK ends the transmission. SDA stays released until the next start.
- R7: Reset values are as follows. Register 0 is 0x83. Registers 1 and 2 are 0x00. Register 3 is {revision[7:4], vendor[3:0]}, which is 0x01 by default. Register 4 is 0x06. Register 5 is 0x06.
- R8: Writes to registers 3 and 4 are acknowledged and discarded.
- R9: Indexes 6 to 255 read as 0x00. Writes to them are acknowledged and have no effect.
- R10: A stop seen in the middle of a byte ends the transfer without storing anything. A repeated start in the middle of a byte returns the block to the address phase.
- R11: When register 0 bit 7 is 1, the bandwidth output equals register 0 bit 1 and the PLL-mode output equals register 0 bit 0. When bit 7 is 0, the two outputs follow the strap inputs.
- R12: The block starts pulling SDA low only while SCL is low.
- R13: The index advances after each data byte and persists across transfers. A read issued without an index phase starts at the advanced index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| strap_bw_high_i | input | 1 | Bandwidth select from a pin, used when register 0 bit 7 is 0 |
| strap_pll_on_i | input | 1 | PLL-mode select from a pin, used when register 0 bit 7 is 0 |
| bw_high_o | output | 1 | Selected PLL bandwidth, 1 = high |
| pll_on_o | output | 1 | Selected mode, 1 = PLL, 0 = bypass |

## Verification
A bit counter that slips by one shows up within the same byte. Every later ACK lands in a data bit, so the next acknowledge the host samples is wrong, and read data appears shifted by one bit. A wrong index pointer or a missed write enable is invisible until a block read returns the register. For that reason every write scenario ends with a readback. A phase machine stuck after an abort shows at the very next address byte, which would then go unacknowledged.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;
  localparam int NUM_REGS  = 6;
  localparam int IDX_W     = 8;
  localparam int SEL_W     = $clog2(NUM_REGS);
  localparam int IDX_CTRL  = 0;
  localparam int IDX_IDREV = 3;
  localparam int IDX_DEVID = 4;
  localparam int IDX_COUNT = 5;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_INDEX, PH_COUNT, PH_WDATA, PH_RDATA, PH_IGNORE
  } phase_e;

  function automatic logic [7:0] reg_default(input int i);
    case (i)
      IDX_CTRL:  return 8'h83;
      IDX_COUNT: return 8'h06;
      default:   return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smbreg_sync.sv
module smbreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;
  assign ev_rise  = scl_s & ~scl_p;
  assign ev_fall  = ~scl_s & scl_p;

  // R10: bus events must be mutually exclusive for the phase machine
  p_events_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start, ev_stop, ev_rise, ev_fall}));
endmodule

// File: rtl/smbreg_regs.sv
module smbreg_regs
  import smbreg_pkg::*;
#(
  parameter logic [7:0] DEV_ID  = 8'h06,
  parameter logic [3:0] REV_ID  = 4'h0,
  parameter logic [3:0] VEND_ID = 4'h1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [7:0]       count_o,
  output logic             ctl_sw_en,
  output logic             ctl_bw,
  output logic             ctl_mode
);
  logic [7:0] regs [NUM_REGS];
  logic [NUM_REGS*8-1:0] snap;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    if (gi == IDX_IDREV) begin : g_idrev
      assign regs[gi] = {REV_ID, VEND_ID};
    end else if (gi == IDX_DEVID) begin : g_devid
      assign regs[gi] = DEV_ID;
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= reg_default(gi);
        else if (wr_en && wr_idx == IDX_W'(gi))
          q <= wr_data;
      end
      assign regs[gi] = q;
    end
    assign snap[gi*8 +: 8] = regs[gi];
  end

  assign rd_data   = (rd_idx < IDX_W'(NUM_REGS)) ? regs[rd_idx[SEL_W-1:0]] : 8'h00;
  assign count_o   = regs[IDX_COUNT];
  assign ctl_sw_en = regs[IDX_CTRL][7];
  assign ctl_bw    = regs[IDX_CTRL][1];
  assign ctl_mode  = regs[IDX_CTRL][0];

  p_oob_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= IDX_W'(NUM_REGS)) |=> $stable(snap));

  p_ro_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == IDX_W'(IDX_IDREV) || wr_idx == IDX_W'(IDX_DEVID))) |=> $stable(snap));
endmodule

// File: rtl/smbreg_proto.sv
module smbreg_proto
  import smbreg_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h6A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_rise,
  input  logic             ev_fall,
  input  logic [7:0]       rd_data,
  input  logic [7:0]       count_val,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);
  phase_e           phase;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg, tx_sh, wr_left, rd_left;
  logic [IDX_W-1:0] ptr;
  logic             in_ack, is_read, host_ack, byte_ok;
  logic             rx_phase;

  assign rd_idx   = ptr;
  assign rx_phase = (phase == PH_ADDR) || (phase == PH_INDEX) ||
                    (phase == PH_COUNT) || (phase == PH_WDATA);

  always_comb begin
    case (phase)
      PH_ADDR:  byte_ok = (shreg[7:1] == ADDR7);
      PH_WDATA: byte_ok = (wr_left != 8'd0);
      default:  byte_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx_sh    <= '0;
      wr_left  <= '0;
      rd_left  <= '0;
      ptr      <= '0;
      in_ack   <= 1'b0;
      is_read  <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (ev_start) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (ev_stop) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (rx_phase) begin
        if (ev_rise && bit_cnt < 4'd8) begin
          shreg   <= {shreg[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (ev_fall && bit_cnt == 4'd8 && !in_ack) begin
          if (byte_ok) begin
            sda_oe <= 1'b1;
            in_ack <= 1'b1;
            case (phase)
              PH_ADDR:  is_read <= shreg[0];
              PH_INDEX: ptr     <= shreg;
              PH_COUNT: wr_left <= shreg;
              PH_WDATA: begin
                wr_en   <= 1'b1;
                wr_idx  <= ptr;
                wr_data <= shreg;
                ptr     <= ptr + 1'b1;
                wr_left <= wr_left - 8'd1;
              end
              default: ;
            endcase
          end else begin
            phase   <= PH_IGNORE;
            bit_cnt <= '0;
          end
        end else if (ev_fall && in_ack) begin
          in_ack  <= 1'b0;
          bit_cnt <= '0;
          sda_oe  <= 1'b0;
          case (phase)
            PH_ADDR: begin
              if (is_read) begin
                phase   <= PH_RDATA;
                tx_sh   <= count_val;
                rd_left <= count_val;
                sda_oe  <= ~count_val[7];
              end else begin
                phase <= PH_INDEX;
              end
            end
            PH_INDEX: phase <= PH_COUNT;
            PH_COUNT: phase <= PH_WDATA;
            default:  phase <= phase;
          endcase
        end
      end else if (phase == PH_RDATA) begin
        if (ev_rise) begin
          if (bit_cnt == 4'd8) begin
            host_ack <= ~sda_s;
            bit_cnt  <= 4'd9;
          end else if (bit_cnt < 4'd8) begin
            bit_cnt <= bit_cnt + 4'd1;
          end
        end else if (ev_fall) begin
          if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
            tx_sh  <= {tx_sh[6:0], 1'b0};
            sda_oe <= ~tx_sh[6];
          end else if (bit_cnt == 4'd8) begin
            sda_oe <= 1'b0;
          end else if (bit_cnt == 4'd9) begin
            bit_cnt <= '0;
            if (host_ack && rd_left != 8'd0) begin
              tx_sh   <= rd_data;
              sda_oe  <= ~rd_data[7];
              ptr     <= ptr + 1'b1;
              rd_left <= rd_left - 8'd1;
            end else begin
              phase <= PH_IGNORE;
            end
          end
        end
      end
    end
  end

  p_pull_in_low_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  p_ignore_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGNORE) |-> !sda_oe);

  p_write_from_data_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(phase) == PH_WDATA);

  p_bitcnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd9);
endmodule

// File: rtl/smb_regblk.sv
module smb_regblk
  import smbreg_pkg::*;
#(
  parameter logic [6:0] ADDR7       = 7'h6A,
  parameter logic [7:0] DEV_ID      = 8'h06,
  parameter logic [3:0] REV_ID      = 4'h0,
  parameter logic [3:0] VEND_ID     = 4'h1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic strap_bw_high_i,
  input  logic strap_pll_on_i,
  output logic bw_high_o,
  output logic pll_on_o
);
  logic scl_s, sda_s, ev_start, ev_stop, ev_rise, ev_fall;
  logic wr_en, sw_en, reg_bw, reg_mode;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data, count_val;

  smbreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  smbreg_proto #(.ADDR7(ADDR7)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .rd_data(rd_data), .count_val(count_val), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe_o)
  );

  smbreg_regs #(.DEV_ID(DEV_ID), .REV_ID(REV_ID), .VEND_ID(VEND_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .count_o(count_val),
    .ctl_sw_en(sw_en), .ctl_bw(reg_bw), .ctl_mode(reg_mode)
  );

  assign bw_high_o = sw_en ? reg_bw   : strap_bw_high_i;
  assign pll_on_o  = sw_en ? reg_mode : strap_pll_on_i;
endmodule

// File: tb/tb_smb_regblk.sv
module tb_smb_regblk;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic strap_bw = 1'b0, strap_pll = 1'b0;
  logic sda_oe, bw_o, pll_o;
  wire  sda_line = ~(host_low | sda_oe);

  int checks = 0, failures = 0, r12_viol = 0;
  logic done = 1'b0;
  logic [7:0] rb [0:15];
  logic [7:0] rcnt;
  logic a;

  always #4 clk = ~clk;

  smb_regblk dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_bw_high_i(strap_bw), .strap_pll_on_i(strap_pll),
    .bw_high_o(bw_o), .pll_on_o(pll_o)
  );

  // R12 monitor: the pull must not begin while the bus clock is high
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && sda_oe && !prev_oe) r12_viol++;
    prev_oe = sda_oe;
  end

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    host_low = 1'b0; wq; scl = 1'b1; wq; host_low = 1'b1; wq; scl = 1'b0; wq;
  endtask

  task automatic bus_stop;
    host_low = 1'b1; wq; scl = 1'b1; wq; host_low = 1'b0; wq;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      host_low = ~b[i]; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    host_low = 1'b0; wq; scl = 1'b1; wq; ack = ~sda_line; wq; scl = 1'b0; wq;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq; scl = 1'b1; wq; b[i] = sda_line; wq; scl = 1'b0; wq;
    end
    host_low = give_ack; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq; host_low = 1'b0;
  endtask

  task automatic read_block(input logic [7:0] idx, input int n);
    bus_start; send_byte(8'hD4, a); chk("R1 wr addr ack", {7'd0, a}, 8'd1);
    send_byte(idx, a); chk("R2 index ack", {7'd0, a}, 8'd1);
    bus_start; send_byte(8'hD5, a); chk("R1 rd addr ack", {7'd0, a}, 8'd1);
    recv_byte(1'b1, rcnt);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rb[i]);
    bus_stop;
  endtask

  task automatic write_block(input logic [7:0] idx, input logic [7:0] cnt,
                             input logic [7:0] d0, input logic [7:0] d1, input int n,
                             output logic ack0, output logic ack1);
    bus_start; send_byte(8'hD4, a); chk("R1 wr addr ack", {7'd0, a}, 8'd1);
    send_byte(idx, a); chk("R2 index ack", {7'd0, a}, 8'd1);
    send_byte(cnt, a); chk("R2 count ack", {7'd0, a}, 8'd1);
    send_byte(d0, ack0);
    ack1 = 1'b0;
    if (n > 1) send_byte(d1, ack1);
    bus_stop;
  endtask

  task automatic t_reset;
    chk("R7 sda released after reset", {7'd0, sda_oe}, 8'd0);
    chk("R11 bw from reg default", {7'd0, bw_o}, 8'd1);
    chk("R11 mode from reg default", {7'd0, pll_o}, 8'd1);
  endtask

  task automatic t_defaults;
    read_block(8'd0, 6);
    chk("R4 count byte first", rcnt, 8'h06);
    chk("R7 reg0", rb[0], 8'h83); chk("R7 reg1", rb[1], 8'h00);
    chk("R7 reg2", rb[2], 8'h00); chk("R7 reg3", rb[3], 8'h01);
    chk("R7 reg4", rb[4], 8'h06); chk("R7 reg5", rb[5], 8'h06);
  endtask

  task automatic t_write_basic;
    logic k0, k1;
    write_block(8'd1, 8'd2, 8'hA5, 8'h5A, 2, k0, k1);
    chk("R2 data0 ack", {7'd0, k0}, 8'd1); chk("R2 data1 ack", {7'd0, k1}, 8'd1);
    read_block(8'd1, 2);
    chk("R2 reg1", rb[0], 8'hA5); chk("R2 reg2", rb[1], 8'h5A);
  endtask

  task automatic t_beyond_count;
    logic k0, k1;
    write_block(8'd2, 8'd1, 8'h11, 8'h22, 2, k0, k1);
    chk("R3 in-count ack", {7'd0, k0}, 8'd1); chk("R3 extra nack", {7'd0, k1}, 8'd0);
    read_block(8'd2, 2);
    chk("R3 reg2 stored", rb[0], 8'h11); chk("R3 reg3 untouched", rb[1], 8'h01);
  endtask

  task automatic t_readonly;
    logic k0, k1;
    write_block(8'd3, 8'd2, 8'hFF, 8'hFF, 2, k0, k1);
    chk("R8 ro ack0", {7'd0, k0}, 8'd1); chk("R8 ro ack1", {7'd0, k1}, 8'd1);
    read_block(8'd3, 2);
    chk("R8 reg3 kept", rb[0], 8'h01); chk("R8 reg4 kept", rb[1], 8'h06);
  endtask

  task automatic t_oob;
    logic k0, k1;
    write_block(8'd7, 8'd1, 8'h55, 8'h00, 1, k0, k1);
    chk("R9 oob write ack", {7'd0, k0}, 8'd1);
    read_block(8'd6, 2);
    chk("R9 idx6 zero", rb[0], 8'h00); chk("R9 idx7 zero", rb[1], 8'h00);
  endtask

  task automatic t_count_limit;
    logic k0, k1;
    logic [7:0] b;
    write_block(8'd5, 8'd1, 8'h02, 8'h00, 1, k0, k1);
    bus_start; send_byte(8'hD4, a); send_byte(8'h00, a);
    bus_start; send_byte(8'hD5, a);
    recv_byte(1'b1, b); chk("R5 count byte", b, 8'h02);
    recv_byte(1'b1, b); chk("R5 first data", b, 8'h83);
    recv_byte(1'b1, b); chk("R5 second data", b, 8'hA5);
    recv_byte(1'b0, b); chk("R5 past count released", b, 8'hFF);
    bus_stop;
    write_block(8'd5, 8'd1, 8'h06, 8'h00, 1, k0, k1);
  endtask

  task automatic t_host_nack;
    logic [7:0] b;
    bus_start; send_byte(8'hD4, a); send_byte(8'h00, a);
    bus_start; send_byte(8'hD5, a);
    recv_byte(1'b1, b); recv_byte(1'b0, b); chk("R6 byte before nack", b, 8'h83);
    recv_byte(1'b0, b); chk("R6 released after nack", b, 8'hFF);
    bus_stop;
  endtask

  task automatic t_bad_addr;
    bus_start; send_byte(8'hA0, a); chk("R1 foreign addr nack", {7'd0, a}, 8'd0);
    send_byte(8'h00, a); chk("R1 ignored byte nack", {7'd0, a}, 8'd0);
    bus_stop;
    read_block(8'd1, 1); chk("R1 foreign write no effect", rb[0], 8'hA5);
  endtask

  task automatic t_ctl;
    logic k0, k1;
    write_block(8'd0, 8'd1, 8'h00, 8'h00, 1, k0, k1);
    strap_bw = 1'b1; strap_pll = 1'b0; wq;
    chk("R11 strap bw", {7'd0, bw_o}, 8'd1); chk("R11 strap mode", {7'd0, pll_o}, 8'd0);
    strap_bw = 1'b0; strap_pll = 1'b1; wq;
    chk("R11 strap bw2", {7'd0, bw_o}, 8'd0); chk("R11 strap mode2", {7'd0, pll_o}, 8'd1);
    write_block(8'd0, 8'd1, 8'h82, 8'h00, 1, k0, k1);
    chk("R11 reg bw", {7'd0, bw_o}, 8'd1); chk("R11 reg mode", {7'd0, pll_o}, 8'd0);
  endtask

  task automatic t_abort;
    logic [7:0] b;
    bus_start; send_byte(8'hD4, a); send_byte(8'h01, a); send_byte(8'h01, a);
    send_bits(8'h00, 4); bus_stop;
    read_block(8'd1, 1); chk("R10 stop mid-byte no store", rb[0], 8'hA5);
    bus_start; send_byte(8'hD4, a); send_bits(8'h00, 3);
    bus_start; send_byte(8'hD5, a); chk("R10 addr after rstart ack", {7'd0, a}, 8'd1);
    recv_byte(1'b0, b); chk("R10 count after rstart", b, 8'h06);
    bus_stop;
  endtask

  task automatic t_autoinc;
    logic k0, k1;
    logic [7:0] b;
    write_block(8'd1, 8'd1, 8'h33, 8'h00, 1, k0, k1);
    bus_start; send_byte(8'hD5, a); chk("R13 direct read ack", {7'd0, a}, 8'd1);
    recv_byte(1'b1, b); chk("R13 count", b, 8'h06);
    recv_byte(1'b0, b); chk("R13 continues at idx2", b, 8'h11);
    bus_stop;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_defaults;
    t_write_basic;
    t_beyond_count;
    t_readonly;
    t_oob;
    t_count_limit;
    t_host_nack;
    t_bad_addr;
    t_abort;
    t_autoinc;
    t_ctl;
    chk("R12 no pull start while SCL high", r12_viol[7:0], 8'd0);
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule